// File: doc/BRIEF.md
# USB Endpoint Handshake Responder

This block sits beside one endpoint of a high-speed USB device controller. The token decoder presents a token together with a snapshot of the endpoint state. The snapshot holds the endpoint type, the bytes held in and free in the endpoint FIFO, the maximum packet size, the byte count of an incoming OUT data packet, and two software control bits: interrupt-pending and send-zero-length. One cycle later the block names the answer the packet engine must give: ACK, NAK, NYET, a data packet of a stated length, or a zero-length packet.

For OUT data the block chooses among accept-and-continue (ACK), accept-but-stop (NYET) and reject (NAK). The choice uses the free space left after the packet, measured against one and two maximum packet sizes. For PING it reports whether one more full packet would fit. For IN it honours a sticky zero-length request before anything else, and then the interrupt-pending gate. After a packet is sent it waits a bounded time for the host's acknowledge. When that acknowledge arrives it raises an acknowledge event and, for a short packet, an end-of-transfer event. On a control endpoint it also clears the zero-length request itself and records that the command has completed.

The sequencer has four states. `ST_IDLE` takes a token and moves to `ST_RESPOND`. `ST_RESPOND` presents the answer for one cycle. It then moves to `ST_WAIT_ACK` if a packet was sent, and back to `ST_IDLE` otherwise. `ST_WAIT_ACK` moves to `ST_ACKED` on the host's acknowledge, or back to `ST_IDLE` when the wait window expires. `ST_ACKED` raises the events for one cycle and returns to `ST_IDLE`.

Top module: `ep_resp_top`

## Requirements
- R1: After reset `resp_valid`, `resp_code` (0 = none), `tx_len`, `out_commit`, `ev_ack`, `ev_eot`, `zlp_pend` and `cmd_done` are all 0.
- R2: An OUT token (`tok_kind` 0) whose `out_len` is at most `fifo_free` is accepted and `out_commit` pulses with the response. The response is NYET (`resp_code` 3) when `fifo_fill` is non-zero and `fifo_free - out_len` is less than 2×`max_pkt`; otherwise it is ACK (`resp_code` 1).
- R3: An OUT token whose `out_len` exceeds `fifo_free` is answered with NAK (`resp_code` 2) and `out_commit` stays 0.
- R4: A PING token (`tok_kind` 1) is answered with ACK when `fifo_free` is at least `max_pkt`, and with NAK otherwise.
- R5: An IN token (`tok_kind` 2) with `zlp_pend` clear gets NAK on an interrupt endpoint (`ep_kind` 2) while `intr_pend` is 0. Otherwise it gets DATA (`resp_code` 4) with `tx_len` = min(`fifo_fill`, `max_pkt`) when `fifo_fill` is non-zero, and NAK when the FIFO is empty.
- R6: While `zlp_pend` is set, every IN token gets a zero-length packet (`resp_code` 5, `tx_len` 0), whatever the FIFO holds and whatever `intr_pend` is.
- R7: `zlp_pend` is set by a `zlp_set` pulse and cleared by a `zlp_clr` pulse, and set wins when both are present. On a control endpoint (`ep_kind` 0) it clears itself in the cycle after the host acknowledges the zero-length packet. On any other endpoint type it stays set.
- R8: A SETUP token (`tok_kind` 3) is answered with ACK and clears `cmd_done`. `cmd_done` is set when a zero-length OUT is accepted on a control endpoint, or when the host acknowledges a zero-length packet sent on a control endpoint. Otherwise it holds.
- R9: `host_ack` received while a sent packet awaits acknowledge raises `ev_ack` for exactly one cycle, in the following cycle.
- R10: `ev_eot` pulses with the response to an accepted OUT whose `out_len` is below `max_pkt`. It also pulses with `ev_ack` when the acknowledged packet's length was below `max_pkt`, zero-length packets included.
- R11: The response appears for exactly one cycle, in the cycle after the token is sampled. Tokens that arrive while a response or an acknowledge is still pending are ignored.
- R12: If no `host_ack` arrives within `ACK_WAIT` cycles after a sent packet's response cycle, the block returns to idle with no `ev_ack` and no change to `zlp_pend`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_valid | input | 1 | Token strobe, one cycle |
| tok_kind | input | 2 | 0 OUT, 1 PING, 2 IN, 3 SETUP |
| ep_kind | input | 2 | 0 control, 1 bulk, 2 interrupt, 3 isochronous |
| out_len | input | LEN_W | Byte count of the OUT data packet |
| fifo_fill | input | CNT_W | Bytes held in the endpoint FIFO |
| fifo_free | input | CNT_W | Bytes free in the endpoint FIFO |
| max_pkt | input | LEN_W | Maximum packet size |
| intr_pend | input | 1 | Software interrupt-pending bit |
| zlp_set | input | 1 | Software pulse: request zero-length packets |
| zlp_clr | input | 1 | Software pulse: withdraw the request |
| host_ack | input | 1 | Host acknowledged the packet sent |
| resp_valid | output | 1 | Response strobe |
| resp_code | output | 3 | 0 none, 1 ACK, 2 NAK, 3 NYET, 4 DATA, 5 ZLP |
| tx_len | output | LEN_W | Bytes to send with DATA |
| out_commit | output | 1 | OUT data is to be written to the FIFO |
| zlp_pend | output | 1 | Zero-length request state |
| cmd_done | output | 1 | Control command complete |
| ev_ack | output | 1 | Acknowledge event pulse |
| ev_eot | output | 1 | End-of-transfer event pulse |

## Verification
The assertions take several things for granted about the inputs. `max_pkt` is non-zero and holds steady from a token until its response has been given. `zlp_set` and `zlp_clr` arrive as single-cycle pulses. `host_ack` is raised only while a sent packet is awaiting acknowledge. The stimulus meets these by keeping `max_pkt` fixed at 64 and leaving idle cycles between tokens. It also raises `host_ack` only after a DATA or ZLP response, with one deliberate exception: an acknowledge given in the response cycle, to show that it is ignored and the wait window then runs out.

// File: rtl/ep_resp_pkg.sv
package ep_resp_pkg;

    typedef enum logic [1:0] {
        TOK_OUT   = 2'd0,
        TOK_PING  = 2'd1,
        TOK_IN    = 2'd2,
        TOK_SETUP = 2'd3
    } tok_kind_e;

    typedef enum logic [1:0] {
        EP_CTRL = 2'd0,
        EP_BULK = 2'd1,
        EP_INTR = 2'd2,
        EP_ISO  = 2'd3
    } ep_kind_e;

    typedef enum logic [2:0] {
        RSP_NONE = 3'd0,
        RSP_ACK  = 3'd1,
        RSP_NAK  = 3'd2,
        RSP_NYET = 3'd3,
        RSP_DATA = 3'd4,
        RSP_ZLP  = 3'd5
    } resp_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RESPOND  = 2'd1,
        ST_WAIT_ACK = 2'd2,
        ST_ACKED    = 2'd3
    } hs_state_e;

    // A response that puts a packet on the bus and expects a handshake back
    function automatic logic sends_packet(resp_e c);
        return (c == RSP_DATA) || (c == RSP_ZLP);
    endfunction

endpackage

// File: rtl/ep_resp_decide.sv
module ep_resp_decide
    import ep_resp_pkg::*;
#(
    parameter int LEN_W = 11,
    parameter int CNT_W = 12
) (
    input  tok_kind_e          tok,
    input  ep_kind_e           ep,
    input  logic [LEN_W-1:0]   out_len,
    input  logic [LEN_W-1:0]   max_pkt,
    input  logic [CNT_W-1:0]   fifo_fill,
    input  logic [CNT_W-1:0]   fifo_free,
    input  logic               intr_pend,
    input  logic               zlp_pend,
    output resp_e              code,
    output logic [LEN_W-1:0]   tx_len,
    output logic               commit,
    output logic               out_short,
    output logic               tx_short,
    output logic               status_out,
    output logic               setup_seen
);
    // Arithmetic width wide enough for 2 x max_pkt and any FIFO count
    localparam int AW = ((CNT_W > LEN_W) ? CNT_W : LEN_W) + 2;

    logic [AW-1:0] len_a, free_a, fill_a, mp_a, mp2_a, room_a, tx_a;
    logic          fits, tight, has_data, ping_room;

    assign len_a     = AW'(out_len);
    assign free_a    = AW'(fifo_free);
    assign fill_a    = AW'(fifo_fill);
    assign mp_a      = AW'(max_pkt);
    assign mp2_a     = mp_a << 1;
    assign fits      = (len_a <= free_a);
    assign room_a    = fits ? (free_a - len_a) : '0;
    assign tight     = (room_a < mp2_a);
    assign has_data  = (fill_a != '0);
    assign ping_room = (free_a >= mp_a);
    assign tx_a      = (fill_a > mp_a) ? mp_a : fill_a;

    always_comb begin
        code       = RSP_NONE;
        tx_len     = '0;
        commit     = 1'b0;
        out_short  = 1'b0;
        tx_short   = 1'b0;
        status_out = 1'b0;
        setup_seen = 1'b0;
        unique case (tok)
            TOK_OUT: begin
                if (!fits) begin
                    code = RSP_NAK;
                end else begin
                    commit     = 1'b1;
                    out_short  = (len_a < mp_a);
                    status_out = (ep == EP_CTRL) && (out_len == '0);
                    code       = (has_data && tight) ? RSP_NYET : RSP_ACK;
                end
            end
            TOK_PING: begin
                code = ping_room ? RSP_ACK : RSP_NAK;
            end
            TOK_IN: begin
                if (zlp_pend) begin
                    code     = RSP_ZLP;
                    tx_short = (mp_a != '0);
                end else if ((ep == EP_INTR) && !intr_pend) begin
                    code = RSP_NAK;
                end else if (has_data) begin
                    code     = RSP_DATA;
                    tx_len   = LEN_W'(tx_a);
                    tx_short = (tx_a < mp_a);
                end else begin
                    code = RSP_NAK;
                end
            end
            TOK_SETUP: begin
                code       = RSP_ACK;
                setup_seen = 1'b1;
            end
            default: code = RSP_NONE;
        endcase
    end

endmodule

// File: rtl/ep_resp_flags.sv
module ep_resp_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic zlp_set,
    input  logic zlp_clr,
    input  logic zlp_hw_clr,
    input  logic cmd_clear,
    input  logic cmd_set,
    output logic zlp_pend,
    output logic cmd_done
);
    // Zero-length request: software set has priority over any clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zlp_pend <= 1'b0;
        end else if (zlp_set) begin
            zlp_pend <= 1'b1;
        end else if (zlp_clr || zlp_hw_clr) begin
            zlp_pend <= 1'b0;
        end
    end

    // Command-complete: a new setup clears it, a finished status stage sets it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_done <= 1'b0;
        end else if (cmd_clear) begin
            cmd_done <= 1'b0;
        end else if (cmd_set) begin
            cmd_done <= 1'b1;
        end
    end

endmodule

// File: rtl/ep_resp_fsm.sv
module ep_resp_fsm
    import ep_resp_pkg::*;
#(
    parameter int LEN_W    = 11,
    parameter int ACK_WAIT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_valid,
    input  logic             host_ack,
    input  resp_e            dec_code,
    input  logic [LEN_W-1:0] dec_len,
    input  logic             dec_commit,
    input  logic             dec_out_short,
    input  logic             dec_tx_short,
    input  logic             dec_ctrl,
    output logic             tok_take,
    output logic             hs_ack,
    output logic             zlp_done_ctrl,
    output logic             resp_valid,
    output resp_e            resp_code,
    output logic [LEN_W-1:0] tx_len,
    output logic             out_commit,
    output logic             ev_ack,
    output logic             ev_eot
);
    localparam int CW = $clog2(ACK_WAIT + 1);
    localparam logic [CW-1:0] WAIT_LAST = CW'(ACK_WAIT - 1);

    hs_state_e        state, state_nxt;
    resp_e            lat_code;
    logic [LEN_W-1:0] lat_len;
    logic             lat_commit, lat_oshort, lat_tshort, lat_ctrl;
    logic [CW-1:0]    wait_cnt;
    logic             wait_over;

    assign tok_take      = (state == ST_IDLE) && tok_valid;
    assign hs_ack        = (state == ST_WAIT_ACK) && host_ack;
    assign wait_over     = (wait_cnt == WAIT_LAST);
    assign zlp_done_ctrl = hs_ack && lat_ctrl && (lat_code == RSP_ZLP);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:     if (tok_valid) state_nxt = ST_RESPOND;
            ST_RESPOND:  state_nxt = sends_packet(lat_code) ? ST_WAIT_ACK : ST_IDLE;
            ST_WAIT_ACK: begin
                if (host_ack)       state_nxt = ST_ACKED;
                else if (wait_over) state_nxt = ST_IDLE;
            end
            ST_ACKED:    state_nxt = ST_IDLE;
            default:     state_nxt = ST_IDLE;
        endcase
    end

    // Decision capture and acknowledge window counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_code   <= RSP_NONE;
            lat_len    <= '0;
            lat_commit <= 1'b0;
            lat_oshort <= 1'b0;
            lat_tshort <= 1'b0;
            lat_ctrl   <= 1'b0;
            wait_cnt   <= '0;
        end else begin
            if (tok_take) begin
                lat_code   <= dec_code;
                lat_len    <= dec_len;
                lat_commit <= dec_commit;
                lat_oshort <= dec_out_short;
                lat_tshort <= dec_tx_short;
                lat_ctrl   <= dec_ctrl;
            end
            if (state == ST_WAIT_ACK) wait_cnt <= wait_cnt + 1'b1;
            else                      wait_cnt <= '0;
        end
    end

    // Outputs from state
    always_comb begin
        resp_valid = 1'b0;
        resp_code  = RSP_NONE;
        tx_len     = '0;
        out_commit = 1'b0;
        ev_ack     = 1'b0;
        ev_eot     = 1'b0;
        unique case (state)
            ST_RESPOND: begin
                resp_valid = 1'b1;
                resp_code  = lat_code;
                tx_len     = lat_len;
                out_commit = lat_commit;
                ev_eot     = lat_oshort;
            end
            ST_ACKED: begin
                ev_ack = 1'b1;
                ev_eot = lat_tshort;
            end
            ST_IDLE, ST_WAIT_ACK: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/ep_resp_top.sv
module ep_resp_top
    import ep_resp_pkg::*;
#(
    parameter int LEN_W    = 11,
    parameter int CNT_W    = 12,
    parameter int ACK_WAIT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_valid,
    input  logic [1:0]       tok_kind,
    input  logic [1:0]       ep_kind,
    input  logic [LEN_W-1:0] out_len,
    input  logic [CNT_W-1:0] fifo_fill,
    input  logic [CNT_W-1:0] fifo_free,
    input  logic [LEN_W-1:0] max_pkt,
    input  logic             intr_pend,
    input  logic             zlp_set,
    input  logic             zlp_clr,
    input  logic             host_ack,
    output logic             resp_valid,
    output logic [2:0]       resp_code,
    output logic [LEN_W-1:0] tx_len,
    output logic             out_commit,
    output logic             zlp_pend,
    output logic             cmd_done,
    output logic             ev_ack,
    output logic             ev_eot
);
    resp_e            dec_code, rsp;
    logic [LEN_W-1:0] dec_len;
    logic             dec_commit, dec_oshort, dec_tshort, dec_status, dec_setup;
    logic             tok_take, hs_ack, zlp_done_ctrl;

    ep_resp_decide #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_decide (
        .tok        (tok_kind_e'(tok_kind)),
        .ep         (ep_kind_e'(ep_kind)),
        .out_len    (out_len),
        .max_pkt    (max_pkt),
        .fifo_fill  (fifo_fill),
        .fifo_free  (fifo_free),
        .intr_pend  (intr_pend),
        .zlp_pend   (zlp_pend),
        .code       (dec_code),
        .tx_len     (dec_len),
        .commit     (dec_commit),
        .out_short  (dec_oshort),
        .tx_short   (dec_tshort),
        .status_out (dec_status),
        .setup_seen (dec_setup)
    );

    ep_resp_fsm #(.LEN_W(LEN_W), .ACK_WAIT(ACK_WAIT)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .tok_valid     (tok_valid),
        .host_ack      (host_ack),
        .dec_code      (dec_code),
        .dec_len       (dec_len),
        .dec_commit    (dec_commit),
        .dec_out_short (dec_oshort),
        .dec_tx_short  (dec_tshort),
        .dec_ctrl      (ep_kind == EP_CTRL),
        .tok_take      (tok_take),
        .hs_ack        (hs_ack),
        .zlp_done_ctrl (zlp_done_ctrl),
        .resp_valid    (resp_valid),
        .resp_code     (rsp),
        .tx_len        (tx_len),
        .out_commit    (out_commit),
        .ev_ack        (ev_ack),
        .ev_eot        (ev_eot)
    );

    ep_resp_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .zlp_set    (zlp_set),
        .zlp_clr    (zlp_clr),
        .zlp_hw_clr (zlp_done_ctrl),
        .cmd_clear  (tok_take && dec_setup),
        .cmd_set    ((tok_take && dec_status) || zlp_done_ctrl),
        .zlp_pend   (zlp_pend),
        .cmd_done   (cmd_done)
    );

    assign resp_code = rsp;

endmodule

// File: rtl/ep_resp_checker.sv
module ep_resp_checker #(
    parameter int LEN_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             resp_valid,
    input logic [2:0]       resp_code,
    input logic [LEN_W-1:0] tx_len,
    input logic [LEN_W-1:0] max_pkt,
    input logic             out_commit,
    input logic             zlp_pend,
    input logic             zlp_clr,
    input logic             cmd_done,
    input logic             ev_ack,
    input logic             ev_eot
);
    assert_single_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ack |=> !ev_ack);

    assert_commit_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_commit |-> (resp_valid && (resp_code == 3'd1 || resp_code == 3'd3)));

    assert_data_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_code == 3'd4) |-> (tx_len != '0 && tx_len <= max_pkt));

    assert_zlp_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_code == 3'd5) |-> (tx_len == '0));

    assert_zlp_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(zlp_pend) |-> (ev_ack || $past(zlp_clr)));

    assert_cmd_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_done) |-> (resp_valid || ev_ack));

    assert_cmd_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_done) |-> resp_valid);

    assert_eot_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ev_eot |-> (resp_valid || ev_ack));

    assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(resp_valid && ev_ack));

endmodule

bind ep_resp_top ep_resp_checker #(.LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .resp_valid (resp_valid),
    .resp_code  (resp_code),
    .tx_len     (tx_len),
    .max_pkt    (max_pkt),
    .out_commit (out_commit),
    .zlp_pend   (zlp_pend),
    .zlp_clr    (zlp_clr),
    .cmd_done   (cmd_done),
    .ev_ack     (ev_ack),
    .ev_eot     (ev_eot)
);

// File: tb/ep_resp_top_bench.sv
`timescale 1ns/1ps
module ep_resp_top_bench;
    localparam int LEN_W    = 11;
    localparam int CNT_W    = 12;
    localparam int ACK_WAIT = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tok_valid = 1'b0;
    logic [1:0]       tok_kind = '0;
    logic [1:0]       ep_kind = '0;
    logic [LEN_W-1:0] out_len = '0;
    logic [CNT_W-1:0] fifo_fill = '0;
    logic [CNT_W-1:0] fifo_free = '0;
    logic [LEN_W-1:0] max_pkt = 11'd64;
    logic             intr_pend = 1'b0;
    logic             zlp_set = 1'b0;
    logic             zlp_clr = 1'b0;
    logic             host_ack = 1'b0;
    logic             resp_valid, out_commit, zlp_pend, cmd_done, ev_ack, ev_eot;
    logic [2:0]       resp_code;
    logic [LEN_W-1:0] tx_len;

    ep_resp_top #(.LEN_W(LEN_W), .CNT_W(CNT_W), .ACK_WAIT(ACK_WAIT)) u_ep_resp_top (
        .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_kind(tok_kind),
        .ep_kind(ep_kind), .out_len(out_len), .fifo_fill(fifo_fill),
        .fifo_free(fifo_free), .max_pkt(max_pkt), .intr_pend(intr_pend),
        .zlp_set(zlp_set), .zlp_clr(zlp_clr), .host_ack(host_ack),
        .resp_valid(resp_valid), .resp_code(resp_code), .tx_len(tx_len),
        .out_commit(out_commit), .zlp_pend(zlp_pend), .cmd_done(cmd_done),
        .ev_ack(ev_ack), .ev_eot(ev_eot)
    );

    always #4 clk = ~clk;  // 125 MHz

    int n_checks = 0;
    int n_fail   = 0;
    bit chk_en   = 1'b0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int    m_ph;      // 0 idle, 1 answering, 2 awaiting ack, 3 acknowledged
    int    m_cnt, m_code, m_len;
    bit    m_commit, m_oshort, m_tshort, m_zero, m_ctl, m_zlp, m_done;
    string m_tag = "R11";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_code = 0; m_len = 0;
            m_commit = 0; m_oshort = 0; m_tshort = 0; m_zero = 0; m_ctl = 0;
            m_zlp = 0; m_done = 0;
        end else begin
            int nph;
            bit zn, dn, hwclr;
            int fill, free, mp, olen;
            nph   = m_ph;
            zn    = m_zlp;
            dn    = m_done;
            hwclr = (m_ph == 2) && host_ack && m_zero && m_ctl;
            fill  = fifo_fill; free = fifo_free; mp = max_pkt; olen = out_len;
            case (m_ph)
                0: if (tok_valid) begin
                    nph = 1;
                    m_ctl = (ep_kind == 2'd0);
                    m_commit = 0; m_oshort = 0; m_tshort = 0; m_zero = 0; m_len = 0;
                    case (tok_kind)
                        2'd0: if (olen > free) begin
                                  m_code = 2; m_tag = "R3";
                              end else begin
                                  m_commit = 1; m_tag = "R2";
                                  m_oshort = (olen < mp);
                                  m_code = (fill > 0 && (free - olen) < 2 * mp) ? 3 : 1;
                                  if (m_ctl && olen == 0) dn = 1;
                              end
                        2'd1: begin m_code = (free >= mp) ? 1 : 2; m_tag = "R4"; end
                        2'd2: if (m_zlp) begin
                                  m_code = 5; m_zero = 1; m_tshort = 1; m_tag = "R6";
                              end else if (ep_kind == 2'd2 && !intr_pend) begin
                                  m_code = 2; m_tag = "R5";
                              end else if (fill == 0) begin
                                  m_code = 2; m_tag = "R5";
                              end else begin
                                  m_code = 4; m_tag = "R5";
                                  m_len = (fill > mp) ? mp : fill;
                                  m_tshort = (m_len < mp);
                              end
                        default: begin m_code = 1; dn = 0; m_tag = "R8"; end
                    endcase
                end
                1: begin nph = (m_code >= 4) ? 2 : 0; m_cnt = 0; end
                2: if (host_ack) begin
                       nph = 3;
                       if (m_zero && m_ctl) dn = 1;
                   end else if (m_cnt == ACK_WAIT - 1) nph = 0;
                   else m_cnt++;
                default: nph = 0;
            endcase
            if (hwclr)   zn = 0;
            if (zlp_clr) zn = 0;
            if (zlp_set) zn = 1;
            m_ph = nph; m_zlp = zn; m_done = dn;
        end
    end

    // Compare the design with the model every cycle, away from the edge
    always @(negedge clk) begin
        if (chk_en && !finished) begin
            int e_code, e_len;
            bit e_valid, e_commit, e_ack, e_eot;
            e_valid  = (m_ph == 1);
            e_code   = e_valid ? m_code : 0;
            e_len    = e_valid ? m_len : 0;
            e_commit = e_valid && m_commit;
            e_ack    = (m_ph == 3);
            e_eot    = (e_valid && m_oshort) || (e_ack && m_tshort);
            check(resp_valid == e_valid, "R11/R12", "resp_valid", resp_valid, e_valid);
            check(resp_code == e_code, m_tag, "resp_code", resp_code, e_code);
            check(tx_len == e_len, m_tag, "tx_len", tx_len, e_len);
            check(out_commit == e_commit, "R2/R3", "out_commit", out_commit, e_commit);
            check(ev_ack == e_ack, "R9/R12", "ev_ack", ev_ack, e_ack);
            check(ev_eot == e_eot, "R10", "ev_eot", ev_eot, e_eot);
            check(zlp_pend == m_zlp, "R7", "zlp_pend", zlp_pend, m_zlp);
            check(cmd_done == m_done, "R8", "cmd_done", cmd_done, m_done);
        end
    end

    // ---------------- stimulus ----------------
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic token(input int kind, input int ep, input int len,
                         input int fill, input int free);
        @(negedge clk);
        tok_kind  = 2'(kind);
        ep_kind   = 2'(ep);
        out_len   = LEN_W'(len);
        fifo_fill = CNT_W'(fill);
        fifo_free = CNT_W'(free);
        tok_valid = 1'b1;
        @(negedge clk);
        tok_valid = 1'b0;
    endtask

    // Host acknowledge sampled n+1 edges after the response cycle began
    task automatic ack_after(input int n);
        repeat (n) @(negedge clk);
        host_ack = 1'b1;
        @(negedge clk);
        host_ack = 1'b0;
    endtask

    task automatic pulse_zlp(input bit s, input bit c);
        @(negedge clk);
        zlp_set = s; zlp_clr = c;
        @(negedge clk);
        zlp_set = 1'b0; zlp_clr = 1'b0;
    endtask

    initial begin
        idle(3);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check(resp_valid == 0 && resp_code == 0 && tx_len == 0 && out_commit == 0,
              "R1", "response outputs", resp_code, 0);
        check(ev_ack == 0 && ev_eot == 0 && zlp_pend == 0 && cmd_done == 0,
              "R1", "flags and events", {zlp_pend, cmd_done, ev_ack, ev_eot}, 0);
        chk_en = 1'b1;
        idle(2);

        // R2: OUT accept thresholds; R3: overflow
        token(0, 1, 64, 0, 512);   idle(2);   // ACK, FIFO was empty
        token(0, 1, 64, 64, 190);  idle(2);   // NYET, 126 left < 128
        token(0, 1, 64, 64, 192);  idle(2);   // ACK, 128 left
        token(0, 1, 100, 10, 90);  idle(2);   // NAK, no room
        token(0, 1, 20, 0, 500);   idle(2);   // ACK, short -> R10 eot
        // R4: PING boundary
        token(1, 1, 0, 0, 64);     idle(2);
        token(1, 1, 0, 0, 63);     idle(2);
        // R5: interrupt gating and data length
        intr_pend = 1'b0;
        token(2, 2, 0, 100, 100);  idle(2);
        intr_pend = 1'b1;
        token(2, 2, 0, 100, 100);  ack_after(1); idle(2);   // R9, full packet
        token(2, 2, 0, 0, 200);    idle(2);
        intr_pend = 1'b0;
        // R11: a token during the acknowledge wait is ignored; R10 short packet
        token(2, 1, 0, 30, 100);
        token(1, 1, 0, 0, 10);
        ack_after(0); idle(2);
        // R6 and R7 on a bulk endpoint: request survives the acknowledge
        pulse_zlp(1, 0);
        token(2, 1, 0, 200, 100);  ack_after(1); idle(2);
        token(2, 2, 0, 200, 100);  ack_after(2); idle(2);   // R6 ignores intr_pend
        pulse_zlp(0, 1);           idle(2);
        // R8 and R7 on a control endpoint
        token(3, 0, 8, 0, 100);    idle(2);
        pulse_zlp(1, 0);
        token(2, 0, 0, 50, 100);   ack_after(1); idle(2);
        token(3, 0, 8, 0, 100);    idle(2);
        token(0, 0, 0, 0, 100);    idle(2);                 // zero-length status OUT
        token(0, 3, 64, 0, 100);   idle(2);                 // cmd_done holds
        // R12: acknowledge in the response cycle is ignored, window expires
        token(2, 1, 0, 64, 100);
        ack_after(0);
        idle(ACK_WAIT + 3);
        token(1, 1, 0, 0, 100);    idle(2);
        // R7: set wins over clear
        pulse_zlp(1, 1);           idle(2);
        token(2, 3, 0, 10, 100);   idle(ACK_WAIT + 3);      // R12 keeps request
        pulse_zlp(0, 1);           idle(3);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule